// File: doc/BRIEF.md
# Fractional-N Serial Bit-Rate Generator

This block turns one of several prescaler tick strobes into the rate enables for a serial channel. A clock-select field picks the source strobe. A divider then counts those strobes. The divider either divides by a plain integer N, or stretches N by a sixteenth-step fraction, so that the average ratio becomes N + (16 − K)/16. The result is the sample tick. A fixed post-divider then forms the bit tick from it. In the asynchronous (UART) mode the post-divider divides by 16, giving sixteen sample ticks per bit. In the synchronous shift-register mode it divides by 2.

The fraction comes from a small phase accumulator. At the start of each divider period, the accumulator adds 16 − K. When that addition carries, the period is one source tick longer than N. Over sixteen periods the carries add up to exactly 16 − K extra ticks. Both outputs are single system-clock pulses. They appear in the same cycle as the source strobe that completes the period, so an integer ratio of one passes every strobe straight through.

Top module: `frac_baud_gen`

## Requirements
- R1: `src_sel` value s (0..3) makes `pre_tick[s]` the only strobe the divider counts; strobes on the other lines have no effect on either output.
- R2: `div_n` gives N; field value 0 means N = 16 and values 1..15 mean themselves; with fractional mode off, every N-th selected strobe raises `sample_tick`.
- R3: With `frac_en` = 0, the value of `frac_k` has no effect on the outputs.
- R4: With `frac_en` = 1, `uart_mode` = 1, N in 2..15 and K in 1..15, a 4-bit accumulator that is cleared by reset adds 16 − K at the start of every period. A period whose addition carries out lasts N + 1 strobes, and any other period lasts N strobes. Sixteen consecutive periods therefore span 16·N + 16 − K strobes.
- R5: When N is 1 or 16, the divider divides by plain N even if `frac_en` = 1.
- R6: With `uart_mode` = 0, no fractional extension is applied, and `baud_tick` rises on every 2nd `sample_tick`.
- R7: With `uart_mode` = 1, `baud_tick` rises on every 16th `sample_tick`.
- R8: A `frac_k` value of 0 with `frac_en` = 1 gives plain divide-by-N.
- R9: While `rst` is high, both outputs stay 0 and all counters clear. After reset, the first `sample_tick` comes with the N-th selected strobe.
- R10: Changes to `div_n`, `frac_k`, `frac_en` or `src_sel` made in the middle of a period leave the length of that period unchanged. The new values govern the period that begins with the next counted strobe.
- R11: `sample_tick` is a one-cycle pulse in the same cycle as the selected strobe that completes a period, and never in a cycle without one. `baud_tick` is high only together with `sample_tick`. With N = 1 and no fraction, every selected strobe yields a `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 4 | Prescaler tick strobes, one cycle each |
| src_sel | input | 2 | Index of the strobe to count |
| div_n | input | 4 | Integer ratio N (0 means 16) |
| frac_k | input | 4 | Fraction field K |
| frac_en | input | 1 | Enables fractional stretching |
| uart_mode | input | 1 | 1 = asynchronous (÷16 post), 0 = synchronous (÷2 post) |
| sample_tick | output | 1 | Divider-period pulse |
| baud_tick | output | 1 | Bit-rate pulse |

## Verification
Both outputs are combinational in the counters. They are therefore due in the very cycle that carries the completing strobe, with no register delay. The bench drives each strobe at the falling edge and reads the outputs one nanosecond later, before the next rising edge commits the counters. Configuration is captured when the first strobe of a period is counted. For this reason the check of mid-period changes counts strobes up to the period end that the old N predicts, and then up to the end that the new N predicts. The fractional cases run a whole number of 16-period cycles, so the accumulator comes back to zero and the last strobe fed in must itself produce a sample tick.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int unsigned FB_N_W = 4;
    localparam int unsigned FB_K_W = 4;

    typedef enum logic {
        MODE_SYNC  = 1'b0,
        MODE_ASYNC = 1'b1
    } ser_mode_e;

    // Length descriptor for one divider period.
    typedef struct packed {
        logic [FB_N_W:0] n;
        logic            ext;
    } period_t;

    // A field of 0 stands for the largest ratio.
    function automatic logic [FB_N_W:0] decode_n(input logic [FB_N_W-1:0] f);
        if (f == '0)
            return (FB_N_W+1)'(1 << FB_N_W);
        return {1'b0, f};
    endfunction

    // The fraction is legal only asynchronously, with N strictly inside the range and K nonzero.
    function automatic logic frac_ok(input logic en, input ser_mode_e m,
                                     input logic [FB_N_W-1:0] nf,
                                     input logic [FB_K_W-1:0] k);
        return en && (m == MODE_ASYNC) && (nf >= (FB_N_W)'(2)) && (k != '0);
    endfunction

    function automatic logic [FB_K_W:0] frac_step(input logic [FB_K_W-1:0] k);
        return (FB_K_W+1)'(1 << FB_K_W) - {1'b0, k};
    endfunction

endpackage

// File: rtl/fbg_tick_select.sv
module fbg_tick_select #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pre_tick,
    input  logic [SEL_W-1:0] src_sel,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign hit[i] = pre_tick[i] && (src_sel == SEL_W'(i));
        end
    endgenerate

    assign tick = |hit;
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div
    import frac_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [FB_N_W-1:0] n_field,
    input  logic [FB_K_W-1:0] k_field,
    input  logic              frac_en,
    input  ser_mode_e         mode,
    output logic              period_done
);
    logic [FB_N_W:0]   cnt;
    logic [FB_K_W-1:0] acc;
    period_t           held;

    logic [FB_K_W:0]   step;
    logic [FB_K_W:0]   sum;
    period_t           live;
    period_t           eff;
    logic              at_start;
    logic [FB_N_W:0]   eff_len;
    logic              last;

    always_comb begin
        step     = frac_ok(frac_en, mode, n_field, k_field) ? frac_step(k_field) : '0;
        sum      = {1'b0, acc} + step;
        live.n   = decode_n(n_field);
        live.ext = sum[FB_K_W];
        at_start = (cnt == '0);
        eff      = at_start ? live : held;
        eff_len  = eff.n + {{FB_N_W{1'b0}}, eff.ext};
        last     = (cnt == eff_len - (FB_N_W+1)'(1));
    end

    assign period_done = tick && last && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            acc  <= '0;
            held <= '0;
        end else if (tick) begin
            if (at_start) begin
                acc  <= sum[FB_K_W-1:0];
                held <= live;
            end
            cnt <= last ? '0 : cnt + (FB_N_W+1)'(1);
        end
    end

    // R11: a period can only end on a counted strobe
    a_r11_done_on_tick: assert property (@(posedge clk) disable iff (rst)
        period_done |-> tick);

    // R10: the captured length holds while a period is running and no strobe arrives
    a_r10_held_stable: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !tick) |=> $stable(held));

    // R5: an extended period never uses N of 1 or 16
    a_r5_ext_range: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && held.ext) |-> (held.n >= (FB_N_W+1)'(2) && held.n <= (FB_N_W+1)'((1 << FB_N_W) - 1)));

    // R4: a running count stays inside the captured period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (cnt < held.n + {{FB_N_W{1'b0}}, held.ext}));
endmodule

// File: rtl/fbg_post_div.sv
module fbg_post_div
    import frac_baud_pkg::*;
#(
    parameter int DIV_ASYNC = 16,
    parameter int DIV_SYNC  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sample,
    input  ser_mode_e mode,
    output logic      bit_tick
);
    localparam int MAXD = (DIV_ASYNC > DIV_SYNC) ? DIV_ASYNC : DIV_SYNC;
    localparam int P_W  = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [P_W-1:0] pcnt;
    logic [P_W-1:0] last_idx;
    logic           wrap;

    assign last_idx = (mode == MODE_ASYNC) ? P_W'(DIV_ASYNC - 1) : P_W'(DIV_SYNC - 1);
    assign wrap     = (pcnt >= last_idx);
    assign bit_tick = sample && wrap && !rst;

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (sample)
            pcnt <= wrap ? '0 : pcnt + P_W'(1);
    end

    // R7: after a bit tick the post-divider restarts from zero
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> (pcnt == '0));

    // R6: in synchronous mode the post count never passes the last index when it produces a tick
    a_r6_sync_tick: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SYNC && sample && pcnt == '0) |-> !bit_tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int NSRC      = 4,
    parameter int SEL_W     = $clog2(NSRC),
    parameter int DIV_ASYNC = 16,
    parameter int DIV_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   pre_tick,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [FB_N_W-1:0] div_n,
    input  logic [FB_K_W-1:0] frac_k,
    input  logic              frac_en,
    input  logic              uart_mode,
    output logic              sample_tick,
    output logic              baud_tick
);
    ser_mode_e mode;
    logic      tick;

    assign mode = ser_mode_e'(uart_mode);

    fbg_tick_select #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
        .pre_tick (pre_tick),
        .src_sel  (src_sel),
        .tick     (tick)
    );

    fbg_frac_div u_div (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .n_field     (div_n),
        .k_field     (frac_k),
        .frac_en     (frac_en),
        .mode        (mode),
        .period_done (sample_tick)
    );

    fbg_post_div #(.DIV_ASYNC(DIV_ASYNC), .DIV_SYNC(DIV_SYNC)) u_post (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample_tick),
        .mode     (mode),
        .bit_tick (baud_tick)
    );

    // R11: a bit tick is always also a sample tick
    a_r11_baud_in_sample: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> sample_tick);

    // R1: a sample tick needs a strobe on the selected line
    a_r1_selected_source: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> pre_tick[src_sel]);
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pre_tick = '0;
    logic [1:0] src_sel = '0;
    logic [3:0] div_n = 4'd1;
    logic [3:0] frac_k = '0;
    logic       frac_en = 1'b0;
    logic       uart_mode = 1'b1;
    logic       sample_tick, baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .src_sel(src_sel),
        .div_n(div_n), .frac_k(frac_k), .frac_en(frac_en), .uart_mode(uart_mode),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [3:0] n;
        logic [3:0] k;
        logic       fe;
        logic       uart;
        logic [8:0] ticks16;   // strobes spanned by sixteen periods
        logic [4:0] baud32;    // bit ticks expected over thirty-two periods
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd5,  4'd3,  1'b0, 1'b1, 9'd80,  5'd2},   // R2 R3
        '{2'd1, 4'd0,  4'd0,  1'b0, 1'b1, 9'd256, 5'd2},   // R2 zero means 16
        '{2'd2, 4'd3,  4'd8,  1'b1, 1'b1, 9'd56,  5'd2},   // R4
        '{2'd3, 4'd7,  4'd1,  1'b1, 1'b1, 9'd127, 5'd2},   // R4
        '{2'd1, 4'd2,  4'd15, 1'b1, 1'b1, 9'd33,  5'd2},   // R4
        '{2'd0, 4'd1,  4'd4,  1'b1, 1'b1, 9'd16,  5'd2},   // R5 N=1
        '{2'd2, 4'd0,  4'd4,  1'b1, 1'b1, 9'd256, 5'd2},   // R5 N=16
        '{2'd3, 4'd6,  4'd4,  1'b1, 1'b0, 9'd96,  5'd16},  // R6
        '{2'd0, 4'd9,  4'd0,  1'b1, 1'b1, 9'd144, 5'd2},   // R8
        '{2'd1, 4'd15, 4'd5,  1'b1, 1'b1, 9'd251, 5'd2},   // R4 R7
        '{2'd2, 4'd4,  4'd9,  1'b0, 1'b0, 9'd64,  5'd16}   // R3 R6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int s_cnt, b_cnt;

    // Cycle in which the selected line strobes (all lines high).
    task automatic hit_cycle(output bit got);
        @(negedge clk);
        pre_tick = '1;
        #1;
        got = sample_tick;
        s_cnt += int'(sample_tick);
        b_cnt += int'(baud_tick);
    endtask

    // Cycle in which only the unselected lines strobe.
    task automatic idle_cycle();
        @(negedge clk);
        pre_tick = ~(4'b0001 << src_sel);
        #1;
        s_cnt += int'(sample_tick);
        b_cnt += int'(baud_tick);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pre_tick = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Feed strobes until a sample tick; return the number of strobes used.
    task automatic measure_period(output int len);
        bit got;
        len = 0;
        got = 0;
        while (!got && len < 40) begin
            hit_cycle(got);
            len++;
            idle_cycle();
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit got, last_got;
        int len, acc_m, exp_len;

        // R9: outputs stay low during reset even with N=1
        src_sel = 2'd0; div_n = 4'd1; frac_en = 0; uart_mode = 1;
        @(negedge clk);
        rst = 1'b1;
        pre_tick = '1;
        #1;
        check(sample_tick == 0 && baud_tick == 0, "R9 reset outputs", int'(sample_tick), 0);
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            src_sel = VECS[v].sel; div_n = VECS[v].n; frac_k = VECS[v].k;
            frac_en = VECS[v].fe; uart_mode = VECS[v].uart;
            do_reset();
            s_cnt = 0; b_cnt = 0; last_got = 0;
            for (int t = 0; t < 2 * int'(VECS[v].ticks16); t++) begin
                hit_cycle(got);
                if (t == 2 * int'(VECS[v].ticks16) - 1) last_got = got;
                idle_cycle();
                idle_cycle();
            end
            check(s_cnt == 32, $sformatf("R1 R2 R4 vec%0d sample count", v), s_cnt, 32);
            check(b_cnt == int'(VECS[v].baud32), $sformatf("R6 R7 vec%0d bit count", v), b_cnt, int'(VECS[v].baud32));
            check(last_got, $sformatf("R4 R5 R8 vec%0d final strobe ends period", v), int'(last_got), 1);
        end

        // R9: first sample after exactly N strobes
        src_sel = 2'd1; div_n = 4'd3; frac_en = 0; uart_mode = 1;
        do_reset();
        s_cnt = 0; b_cnt = 0;
        measure_period(len);
        check(len == 3, "R9 first period", len, 3);

        // R4: exact period pattern, N=3 K=12
        div_n = 4'd3; frac_k = 4'd12; frac_en = 1; uart_mode = 1;
        do_reset();
        acc_m = 0;
        for (int p = 0; p < 8; p++) begin
            acc_m += 16 - 12;
            exp_len = (acc_m >= 16) ? 4 : 3;
            acc_m = acc_m % 16;
            measure_period(len);
            check(len == exp_len, $sformatf("R4 period %0d", p), len, exp_len);
        end

        // R10: mid-period change to N
        div_n = 4'd4; frac_en = 0;
        do_reset();
        hit_cycle(got); idle_cycle();
        hit_cycle(got); idle_cycle();
        div_n = 4'd2;
        hit_cycle(got); idle_cycle();
        check(got == 0, "R10 third strobe of old period", int'(got), 0);
        hit_cycle(got); idle_cycle();
        check(got == 1, "R10 old period ends at four", int'(got), 1);
        measure_period(len);
        check(len == 2, "R10 new period length", len, 2);

        // R11: N=1 passes every strobe, nothing between strobes
        div_n = 4'd1; frac_en = 1; frac_k = 4'd7;
        do_reset();
        s_cnt = 0; b_cnt = 0;
        for (int t = 0; t < 32; t++) begin
            hit_cycle(got);
            check(got == 1, "R11 pass-through", int'(got), 1);
            idle_cycle();
        end
        check(s_cnt == 32, "R11 no extra pulses", s_cnt, 32);
        check(b_cnt == 2, "R7 N=1 bit ticks", b_cnt, 2);

        // R3: K change with fraction off leaves period unchanged
        div_n = 4'd5; frac_en = 0; frac_k = 4'd1;
        do_reset();
        measure_period(len);
        frac_k = 4'd14;
        measure_period(len);
        check(len == 5, "R3 K ignored", len, 5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule